// File: doc/BRIEF.md
# Boot Region Write Guard

This block sits in front of the program and erase engine of a 512K x 8 flash array. It holds a lockout setting that can be applied once per end of the address space: either a 16 KB or a 64 KB region at the top or the bottom end. Every program or erase request passes through it. The block answers each request with a registered allow/deny verdict one cycle later. A locked region cannot be changed by a byte program, by a sector or page erase that reaches into it, or by a chip erase.

Lock settings arrive as a strobe that carries the command byte and the address of the final write of the lock sequence. The command byte selects the size and the address selects the end. The top and bottom settings are stored separately and cannot be changed until reset; reset stands in for the factory-clear state. A two-bit status is produced for the identification readout at two fixed status addresses, one for each end.

Top module: `boot_lock_guard`

## Requirements
- R1: After reset neither end is locked, `stat_bits` reads 00b and `grant_valid` is low.
- R2: A lock strobe with `lock_code` 40h sets a 64 KB lock and 70h sets a 16 KB lock. `lock_addr` 7FFFFh selects the top end and 00000h selects the bottom end. A strobe with any other code or address changes nothing.
- R3: A top lock covers 7C000h–7FFFFh at 16 KB and 70000h–7FFFFh at 64 KB.
- R4: A bottom lock covers 00000h–03FFFh at 16 KB and 00000h–0FFFFh at 64 KB.
- R5: A program request (`req_kind` 00b) is answered on the cycle after it is presented, with `grant_valid` high for one cycle. `grant_ok` is 0 inside a locked range and 1 everywhere else.
- R6: A sector erase (`req_kind` 01b, aligned 64 KB around `req_addr`) or a page erase (`req_kind` 10b, aligned 4 KB) is refused as a whole when its range overlaps any locked region.
- R7: A chip erase (`req_kind` 11b) is refused when either end is locked and allowed when neither is.
- R8: Once an end is locked, later lock strobes for that end are ignored and its size does not change. Only reset clears it.
- R9: The top and bottom locks are independent, so both ends can be locked at the same time.
- R10: `stat_bits` is registered from `stat_addr` one cycle later. Address 00002h reports the bottom end and 7FFF2h reports the top end. The encoding is 10b for a 16 KB lock, 11b for a 64 KB lock and 00b for no lock. Every other address reads 00b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears both locks |
| lock_valid | input | 1 | Lock-set strobe |
| lock_code | input | 8 | Command byte of the lock sequence (size select) |
| lock_addr | input | 19 | Address of the final lock write (end select) |
| req_valid | input | 1 | Program/erase request strobe |
| req_kind | input | 2 | 00 program, 01 sector erase, 10 page erase, 11 chip erase |
| req_addr | input | 19 | Request address |
| stat_addr | input | 19 | Identification readout address |
| grant_valid | output | 1 | Verdict valid, one cycle after the request |
| grant_ok | output | 1 | 1 allow, 0 deny |
| stat_bits | output | 2 | Lockout status for the readout |

## Verification
The bench probes the addresses on either side of each region boundary: 7BFFFh against 7C000h, and 0FFFFh against 10000h. A design with an off-by-one bound would allow or refuse the wrong one of each pair. Erases whose base address lies outside a region but whose aligned range reaches into it are also tried. A guard that compared only the request address would let them through. Relocking an end with the other size checks that a lock cannot be changed after it is set. Strobes with an unknown code or a wrong address check that invalid strobes are ignored; a loose decoder would lock the array by mistake. Status reads at both status addresses and at a neighbouring address show a swapped or mis-encoded status.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;
  typedef enum logic [1:0] {
    KIND_PROG   = 2'b00,
    KIND_SECTOR = 2'b01,
    KIND_PAGE   = 2'b10,
    KIND_CHIP   = 2'b11
  } req_kind_e;

  localparam int END_BOT = 0;
  localparam int END_TOP = 1;
  localparam int NUM_ENDS = 2;
endpackage

// File: rtl/lock_slot.sv
// One end's sticky lock setting.
module lock_slot #(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_valid,
  input  logic              code_ok,
  input  logic              code_big,
  input  logic [ADDR_W-1:0] set_addr,
  output logic              locked,
  output logic              big
);
  logic take;
  assign take = set_valid && code_ok && (set_addr == TRIG_ADDR) && !locked;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      big    <= 1'b0;
    end else if (take) begin
      locked <= 1'b1;
      big    <= code_big;
    end
  end
endmodule

// File: rtl/req_span.sv
// Turns a request into the inclusive address range it touches.
module req_span
  import boot_lock_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int PAGE_W   = 12,
  parameter int SECTOR_W = 16
) (
  input  logic [1:0]        kind,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi
);
  localparam logic [ADDR_W-1:0] PAGE_MASK   = ADDR_W'((64'd1 << PAGE_W) - 64'd1);
  localparam logic [ADDR_W-1:0] SECTOR_MASK = ADDR_W'((64'd1 << SECTOR_W) - 64'd1);

  always_comb begin
    unique case (req_kind_e'(kind))
      KIND_PROG: begin
        lo = addr;
        hi = addr;
      end
      KIND_SECTOR: begin
        lo = addr & ~SECTOR_MASK;
        hi = addr | SECTOR_MASK;
      end
      KIND_PAGE: begin
        lo = addr & ~PAGE_MASK;
        hi = addr | PAGE_MASK;
      end
      default: begin
        lo = '0;
        hi = '1;
      end
    endcase
  end
endmodule

// File: rtl/region_hit.sv
// Overlap test of a range against one end's locked region.
module region_hit #(
  parameter int ADDR_W  = 19,
  parameter int SMALL_W = 14,
  parameter int LARGE_W = 16,
  parameter bit IS_TOP  = 1'b0
) (
  input  logic              locked,
  input  logic              big,
  input  logic [ADDR_W-1:0] lo,
  input  logic [ADDR_W-1:0] hi,
  output logic              hit
);
  localparam logic [ADDR_W-1:0] SMALL_MASK = ADDR_W'((64'd1 << SMALL_W) - 64'd1);
  localparam logic [ADDR_W-1:0] LARGE_MASK = ADDR_W'((64'd1 << LARGE_W) - 64'd1);

  generate
    if (IS_TOP) begin : g_top
      logic [ADDR_W-1:0] floor_a;
      assign floor_a = big ? ~LARGE_MASK : ~SMALL_MASK;
      assign hit = locked && (hi >= floor_a);
    end else begin : g_bot
      logic [ADDR_W-1:0] ceil_a;
      assign ceil_a = big ? LARGE_MASK : SMALL_MASK;
      assign hit = locked && (lo <= ceil_a);
    end
  endgenerate
endmodule

// File: rtl/boot_lock_guard.sv
module boot_lock_guard
  import boot_lock_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int CODE_W   = 8,
  parameter int SMALL_W  = 14,
  parameter int LARGE_W  = 16,
  parameter int PAGE_W   = 12,
  parameter int SECTOR_W = 16,
  parameter logic [CODE_W-1:0] CODE_LARGE = 8'h40,
  parameter logic [CODE_W-1:0] CODE_SMALL = 8'h70,
  parameter logic [ADDR_W-1:0] STAT_BOT_ADDR = 19'h00002,
  parameter logic [ADDR_W-1:0] STAT_TOP_ADDR = 19'h7FFF2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lock_valid,
  input  logic [CODE_W-1:0] lock_code,
  input  logic [ADDR_W-1:0] lock_addr,
  input  logic              req_valid,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [ADDR_W-1:0] stat_addr,
  output logic              grant_valid,
  output logic              grant_ok,
  output logic [1:0]        stat_bits
);
  logic code_ok, code_big;
  assign code_big = (lock_code == CODE_LARGE);
  assign code_ok  = code_big || (lock_code == CODE_SMALL);

  logic [ADDR_W-1:0] span_lo, span_hi;
  req_span #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .SECTOR_W(SECTOR_W)) u_span (
    .kind(req_kind), .addr(req_addr), .lo(span_lo), .hi(span_hi)
  );

  logic [NUM_ENDS-1:0] locked_vec, big_vec, hit_vec;

  for (genvar e = 0; e < NUM_ENDS; e++) begin : g_end
    localparam bit IS_TOP = (e == END_TOP);
    localparam logic [ADDR_W-1:0] TRIG = IS_TOP ? '1 : '0;

    lock_slot #(.ADDR_W(ADDR_W), .TRIG_ADDR(TRIG)) u_slot (
      .clk(clk), .rst(rst), .set_valid(lock_valid), .code_ok(code_ok),
      .code_big(code_big), .set_addr(lock_addr),
      .locked(locked_vec[e]), .big(big_vec[e])
    );

    region_hit #(.ADDR_W(ADDR_W), .SMALL_W(SMALL_W), .LARGE_W(LARGE_W),
                 .IS_TOP(IS_TOP)) u_hit (
      .locked(locked_vec[e]), .big(big_vec[e]),
      .lo(span_lo), .hi(span_hi), .hit(hit_vec[e])
    );
  end

  logic [1:0] stat_next;
  always_comb begin
    stat_next = 2'b00;
    if (stat_addr == STAT_BOT_ADDR)
      stat_next = {locked_vec[END_BOT], locked_vec[END_BOT] & big_vec[END_BOT]};
    else if (stat_addr == STAT_TOP_ADDR)
      stat_next = {locked_vec[END_TOP], locked_vec[END_TOP] & big_vec[END_TOP]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_valid <= 1'b0;
      grant_ok    <= 1'b0;
      stat_bits   <= 2'b00;
    end else begin
      grant_valid <= req_valid;
      grant_ok    <= req_valid && (hit_vec == '0);
      stat_bits   <= stat_next;
    end
  end
endmodule

// File: rtl/boot_lock_guard_chk.sv
module boot_lock_guard_chk #(
  parameter int ADDR_W = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [1:0]        req_kind,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] stat_addr,
  input logic              grant_valid,
  input logic              grant_ok,
  input logic [1:0]        stat_bits,
  input logic [1:0]        locked_vec,
  input logic [1:0]        big_vec
);
  // R1
  a_r1_idle_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!grant_valid && stat_bits == 2'b00 && locked_vec == 2'b00));

  // R5
  a_r5_verdict_next_cycle: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (grant_valid == $past(req_valid)));

  // R5: top 16 KB boundary for programs
  a_r5_top_prog_denied: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_kind) == 2'b00 &&
     $past(locked_vec[1]) && $past(req_addr) >= 19'h7C000) |-> !grant_ok);

  // R7
  a_r7_chip_denied: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_valid) && $past(req_kind) == 2'b11 &&
     $past(locked_vec) != 2'b00) |-> !grant_ok);

  // R8
  a_r8_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(locked_vec[1])) |->
      (locked_vec[1] && big_vec[1] == $past(big_vec[1])));

  // R10
  a_r10_other_addr_zero: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(stat_addr) != 19'h00002 && $past(stat_addr) != 19'h7FFF2)
      |-> stat_bits == 2'b00);
endmodule

bind boot_lock_guard boot_lock_guard_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
  .req_addr(req_addr), .stat_addr(stat_addr), .grant_valid(grant_valid),
  .grant_ok(grant_ok), .stat_bits(stat_bits),
  .locked_vec(locked_vec), .big_vec(big_vec)
);

// File: tb/boot_lock_guard_test.sv
module boot_lock_guard_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lock_valid = 1'b0;
  logic [7:0]  lock_code = '0;
  logic [18:0] lock_addr = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_kind = '0;
  logic [18:0] req_addr = '0;
  logic [18:0] stat_addr = 19'h12345;
  logic        grant_valid, grant_ok;
  logic [1:0]  stat_bits;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_lock_guard uut (
    .clk(clk), .rst(rst), .lock_valid(lock_valid), .lock_code(lock_code),
    .lock_addr(lock_addr), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .stat_addr(stat_addr), .grant_valid(grant_valid),
    .grant_ok(grant_ok), .stat_bits(stat_bits)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
  endtask

  task automatic set_lock(input logic [7:0] code, input logic [18:0] a);
    @(negedge clk);
    lock_valid = 1'b1; lock_code = code; lock_addr = a;
    @(negedge clk);
    lock_valid = 1'b0;
  endtask

  task automatic ask(input string tag, input logic [1:0] k, input logic [18:0] a, input bit exp_ok);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, int'(grant_valid), 1);
    check(tag, int'(grant_ok), int'(exp_ok));
    @(negedge clk);
    check({tag, " valid drop"}, int'(grant_valid), 0);
  endtask

  task automatic peek(input string tag, input logic [18:0] a, input logic [1:0] exp);
    @(negedge clk);
    stat_addr = a;
    @(negedge clk);
    check(tag, int'(stat_bits), int'(exp));
    stat_addr = 19'h12345;
  endtask

  task automatic t_reset_state();
    do_reset();
    check("R1 grant_valid", int'(grant_valid), 0);
    peek("R1 bottom status", 19'h00002, 2'b00);
    peek("R1 top status", 19'h7FFF2, 2'b00);
    ask("R7 chip erase unlocked", 2'b11, 19'h0, 1'b1);
  endtask

  task automatic t_bad_strobes();
    do_reset();
    set_lock(8'h55, 19'h7FFFF);
    set_lock(8'h40, 19'h7FFFE);
    set_lock(8'h70, 19'h00001);
    peek("R2 bad code/addr top", 19'h7FFF2, 2'b00);
    peek("R2 bad code/addr bottom", 19'h00002, 2'b00);
    ask("R2 ignored strobes leave top writable", 2'b00, 19'h7FFFF, 1'b1);
  endtask

  task automatic t_top_small();
    do_reset();
    set_lock(8'h70, 19'h7FFFF);
    peek("R10 top 16K status", 19'h7FFF2, 2'b10);
    peek("R10 bottom unaffected", 19'h00002, 2'b00);
    peek("R10 neighbour address", 19'h7FFF3, 2'b00);
    ask("R3 prog 7BFFF", 2'b00, 19'h7BFFF, 1'b1);
    ask("R3 prog 7C000", 2'b00, 19'h7C000, 1'b0);
    ask("R5 prog 00000", 2'b00, 19'h00000, 1'b1);
    ask("R6 page 7B000", 2'b10, 19'h7B123, 1'b1);
    ask("R6 page 7C000", 2'b10, 19'h7C800, 1'b0);
    ask("R6 sector overlap from 70000", 2'b01, 19'h70000, 1'b0);
    ask("R6 sector 60000", 2'b01, 19'h6ABCD, 1'b1);
    ask("R7 chip erase top locked", 2'b11, 19'h0, 1'b0);
    set_lock(8'h40, 19'h7FFFF);
    peek("R8 relock keeps 16K", 19'h7FFF2, 2'b10);
    ask("R8 prog 70000 still allowed", 2'b00, 19'h70000, 1'b1);
  endtask

  task automatic t_both_ends();
    do_reset();
    set_lock(8'h40, 19'h00000);
    peek("R10 bottom 64K status", 19'h00002, 2'b11);
    peek("R9 top still open", 19'h7FFF2, 2'b00);
    ask("R4 prog 0FFFF", 2'b00, 19'h0FFFF, 1'b0);
    ask("R4 prog 10000", 2'b00, 19'h10000, 1'b1);
    ask("R6 page 0F000", 2'b10, 19'h0F000, 1'b0);
    set_lock(8'h70, 19'h00000);
    peek("R8 bottom keeps 64K", 19'h00002, 2'b11);
    set_lock(8'h40, 19'h7FFFF);
    peek("R9 top 64K status", 19'h7FFF2, 2'b11);
    peek("R9 bottom kept", 19'h00002, 2'b11);
    ask("R3 prog 70000 64K", 2'b00, 19'h70000, 1'b0);
    ask("R3 prog 6FFFF 64K", 2'b00, 19'h6FFFF, 1'b1);
    ask("R9 mid sector", 2'b01, 19'h40000, 1'b1);
  endtask

  task automatic t_bottom_small();
    do_reset();
    set_lock(8'h70, 19'h00000);
    peek("R10 bottom 16K status", 19'h00002, 2'b10);
    ask("R4 prog 03FFF", 2'b00, 19'h03FFF, 1'b0);
    ask("R4 prog 04000", 2'b00, 19'h04000, 1'b1);
    ask("R6 sector 0 overlaps", 2'b01, 19'h08000, 1'b0);
    ask("R7 chip erase bottom locked", 2'b11, 19'h7FFFF, 1'b0);
    do_reset();
    peek("R1 reset clears lock", 19'h00002, 2'b00);
    ask("R1 prog after reset", 2'b00, 19'h00000, 1'b1);
  endtask

  initial begin
    t_reset_state();
    t_bad_strobes();
    t_top_small();
    t_both_ends();
    t_bottom_small();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule